// File: doc/BRIEF.md
# Two-Port Shared Line Memory with Access Latency

This block is a small line-organised memory that two requesters share: a data-side port (port 0, MEM) and an instruction-side port (port 1, FETCH). Each request moves one whole line of four 32-bit words, either as a read or as a write. The address given with a request is a word address. Dividing it by four selects the line, so the two low address bits are ignored for line selection.

Only one access can be in flight at a time, and each access costs a fixed number of wait cycles, `DELAY`. A requester holds its request, with the same direction, address and data, until it sees `ok_o`. On every cycle before that it is waiting. The port that wins the memory keeps it until its access completes or it withdraws its request, and the other port is held off meanwhile. Stored contents change only on the cycle a write completes. Read data appears only on the cycle a read completes.

The control is a two-state machine. In `IDLE`, a request is granted: the transition *grant* goes to `BUSY` when `DELAY > 0`, and the transition *immediate* completes in place when `DELAY = 0`. In `BUSY`, *count* stays in `BUSY` while the owner still requests and its wait cycles are not used up. *Complete* returns to `IDLE` on the owner's OK cycle. *Abandon* returns to `IDLE` when the owner drops its request early.

Top module: `shared_line_mem`

## Requirements
- R1: After reset every line reads back as all zeros, and no `ok_o` or `err_o` bit is high while no port requests.
- R2: With `DELAY = N`, a port that holds its request on an idle memory sees `ok_o` low for N cycles and high on cycle N+1, in the same cycle as that presentation (`DELAY = 0` gives OK on the first cycle).
- R3: While a write waits, or after it is abandoned, the stored line is unchanged. The written line is visible to any read granted after the write's OK cycle.
- R4: `rdata_o` of a port is all zeros except on the OK cycle of an in-range read on that port, when it carries the addressed line (word k at bits 32k+31..32k).
- R5: While one port owns the memory, the other port gets no OK, including on the owner's OK cycle. Once the owner completes, the stalled port waits a fresh N cycles before its own OK.
- R6: Word addresses 4L to 4L+3 all select line L.
- R7: When both ports request in the same cycle on an idle memory, the port most recently denied wins. After reset, port 0 (MEM) wins.
- R8: If the owner drops its request before its OK, the access is abandoned and the memory is free for the next cycle.
- R9: A word address of `NUM_LINES*4` or above takes the same latency, then completes with `ok_o` and `err_o` both high, returns zero data and changes no line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Request held per port (bit 0 MEM, bit 1 FETCH) |
| we_i | input | 2 | Per port: 1 write, 0 read |
| addr_i | input | 2 x ADDR_W | Per-port word address |
| wdata_i | input | 2 x 128 | Per-port line to write |
| ok_o | output | 2 | Per-port completion (low while requesting means wait) |
| err_o | output | 2 | Per-port out-of-range flag, only with `ok_o` |
| rdata_o | output | 2 x 128 | Per-port read line, valid on the OK cycle |

## Verification
The responses are combinational from the current request and the controller state. The OK for an access therefore appears in the same cycle as its N+1th presentation, and a completed write is visible from the next clock edge onward. The bench drives inputs on the falling edge. It samples the responses one and two time units later, within that same cycle and before the rising edge that commits it. Expected wait counts, including the stall cycles added by the other port, are worked out per scenario before the run. Read lines are predicted from a shadow copy that is updated only on write OKs.

// File: rtl/slm_pkg.sv
package slm_pkg;
    localparam int NUM_PORTS  = 2;
    localparam int PORT_MEM   = 0;
    localparam int PORT_FETCH = 1;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/slm_arbiter.sv
module slm_arbiter
    import slm_pkg::*;
#(
    parameter int DELAY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req_i,
    output logic                 port_o,
    output logic                 done_o
);
    localparam int CNT_W = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

    arb_state_e state_q, state_d;
    logic             owner_q, owner_d;
    logic             prefer_q, prefer_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             active;
    logic             pick;
    logic             done;

    // Output process: who is served this cycle and whether it completes.
    always_comb begin
        active = 1'b0;
        pick   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (|req_i) begin
                    active = 1'b1;
                    pick   = (req_i[0] && req_i[1]) ? prefer_q : req_i[1];
                    done   = (DELAY == 0);
                end
            end
            ARB_BUSY: begin
                if (req_i[owner_q]) begin
                    active = 1'b1;
                    pick   = owner_q;
                    done   = (cnt_q == CNT_W'(DELAY));
                end
            end
            default: ;
        endcase
    end

    // Transition process: grant, immediate, count, complete, abandon.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (active && !done) begin
                    state_d = ARB_BUSY;
                    owner_d = pick;
                    cnt_d   = CNT_W'(1);
                end
            end
            ARB_BUSY: begin
                if (!active || done) begin
                    state_d = ARB_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    // A requesting port that is not served becomes the tie winner.
    always_comb begin
        prefer_d = prefer_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_i[p] && !(active && pick == 1'(p))) begin
                prefer_d = 1'(p);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            owner_q  <= 1'b0;
            prefer_q <= 1'(PORT_MEM);
            cnt_q    <= '0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            prefer_q <= prefer_d;
            cnt_q    <= cnt_d;
        end
    end

    assign port_o = pick;
    assign done_o = done;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DELAY));

    assert_fresh_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ARB_BUSY) |-> cnt_q == CNT_W'(1));

    assert_hold_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_BUSY && req_i[owner_q] && !done_o)
        |=> (state_q == ARB_BUSY && owner_q == $past(owner_q)));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_BUSY && !req_i[owner_q]) |=> state_q == ARB_IDLE);
endmodule

// File: rtl/slm_store.sv
module slm_store #(
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = 128,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [LINE_W-1:0] rd_line_o
);
    logic [NUM_LINES-1:0][LINE_W-1:0] lines_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else if (wr_en_i) begin
            lines_q[wr_idx_i] <= wr_line_i;
        end
    end

    assign rd_line_o = lines_q[rd_idx_i];

    assert_quiet_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(lines_q));
endmodule

// File: rtl/shared_line_mem.sv
module shared_line_mem
    import slm_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int DELAY      = 3,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_PORTS-1:0]                    req_i,
    input  logic [NUM_PORTS-1:0]                    we_i,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]        addr_i,
    input  logic [NUM_PORTS-1:0][WORD_W*LINE_WORDS-1:0] wdata_i,
    output logic [NUM_PORTS-1:0]                    ok_o,
    output logic [NUM_PORTS-1:0]                    err_o,
    output logic [NUM_PORTS-1:0][WORD_W*LINE_WORDS-1:0] rdata_o
);
    localparam int LINE_W    = WORD_W * LINE_WORDS;
    localparam int OFS_W     = $clog2(LINE_WORDS);
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int WORD_SPAN = NUM_LINES * LINE_WORDS;

    logic              sel;
    logic              done;
    logic [IDX_W-1:0]  idx [NUM_PORTS];
    logic [NUM_PORTS-1:0] in_range;
    logic [LINE_W-1:0] rd_line;
    logic              wr_en;

    slm_arbiter #(.DELAY(DELAY)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .port_o (sel),
        .done_o (done)
    );

    assign wr_en = done && we_i[sel] && in_range[sel];

    slm_store #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (idx[sel]),
        .wr_line_i (wdata_i[sel]),
        .rd_idx_i  (idx[sel]),
        .rd_line_o (rd_line)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign idx[p]      = addr_i[p][OFS_W +: IDX_W];
        assign in_range[p] = (32'(addr_i[p]) < 32'(WORD_SPAN));
        assign ok_o[p]     = done && (sel == 1'(p));
        assign err_o[p]    = ok_o[p] && !in_range[p];
        assign rdata_o[p]  = (ok_o[p] && !we_i[p] && in_range[p]) ? rd_line : '0;

        assert_ok_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ok_o[p] |-> req_i[p]);
    end

    assert_single_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ok_o));

    assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_o) |-> !wr_en);
endmodule

// File: tb/tb_shared_line_mem.sv
module tb_shared_line_mem;
    localparam int CLK_P = 10;
    localparam int NL    = 16;
    localparam int D     = 3;
    localparam int LW    = 128;

    typedef struct packed {
        logic          err;
        logic [LW-1:0] data;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req = '0, we = '0;
    logic [1:0][7:0] addr = '0;
    logic [1:0][LW-1:0] wdata = '0;
    logic [1:0] ok, err;
    logic [1:0][LW-1:0] rdata;

    logic [1:0] z_req = '0, z_we = '0;
    logic [1:0][7:0] z_addr = '0;
    logic [1:0][LW-1:0] z_wdata = '0;
    logic [1:0] z_ok, z_err;
    logic [1:0][LW-1:0] z_rdata;

    int checks = 0;
    int errors = 0;
    logic [LW-1:0] shadow [NL];
    item_t q0 [$];
    item_t q1 [$];

    always #(CLK_P/2) clk = ~clk;

    shared_line_mem #(.NUM_LINES(NL), .DELAY(D)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .ok_o(ok), .err_o(err), .rdata_o(rdata)
    );

    shared_line_mem #(.NUM_LINES(NL), .DELAY(0)) dut_z (
        .clk(clk), .rst_n(rst_n), .req_i(z_req), .we_i(z_we), .addr_i(z_addr),
        .wdata_i(z_wdata), .ok_o(z_ok), .err_o(z_err), .rdata_o(z_rdata)
    );

    function automatic logic [LW-1:0] mk_line(int base);
        logic [LW-1:0] l;
        for (int k = 0; k < 4; k++) l[32*k +: 32] = 32'(base + k);
        return l;
    endfunction

    task automatic check(bit cond, string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: entered just after a falling edge; pushes the expected result.
    task automatic run_access(int p, bit w, int a, logic [LW-1:0] d, int exp_waits, string tag);
        item_t it;
        int waits = 0;
        bit bad = (a >= NL*4);
        it.err  = bad;
        it.data = (w || bad) ? '0 : shadow[(a/4) % NL];
        if (p == 0) q0.push_back(it); else q1.push_back(it);
        req[p] = 1'b1; we[p] = w; addr[p] = 8'(a); wdata[p] = d;
        forever begin
            #1;
            if (ok[p]) break;
            check(rdata[p] == '0, {tag, " R4 rdata during wait"}, rdata[p], '0);
            waits++;
            if (waits > 100) break;
            @(negedge clk);
        end
        check(waits == exp_waits, {tag, " wait count"}, LW'(waits), LW'(exp_waits));
        if (w && !bad) shadow[a/4] = d;
        @(negedge clk);
        req[p] = 1'b0;
    endtask

    task automatic partial_access(int p, bit w, int a, logic [LW-1:0] d, int cycles);
        req[p] = 1'b1; we[p] = w; addr[p] = 8'(a); wdata[p] = d;
        repeat (cycles) begin
            #1;
            check(!ok[p], "R8 abandoned access got ok", LW'(ok[p]), '0);
            @(negedge clk);
        end
        req[p] = 1'b0;
    endtask

    // Monitor: pops the per-port scoreboard on every OK.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            for (int p = 0; p < 2; p++) begin
                if (ok[p]) begin
                    if ((p == 0 ? q0.size() : q1.size()) == 0) begin
                        check(1'b0, "R2 unexpected ok", LW'(p), '0);
                    end else begin
                        it = (p == 0) ? q0.pop_front() : q1.pop_front();
                        check(err[p] == it.err, "R9 err flag", LW'(err[p]), LW'(it.err));
                        check(rdata[p] == it.data, "R4 R6 read line", rdata[p], it.data);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL R2 watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ok == 2'b00 && err == 2'b00, "R1 idle ok/err after reset", LW'({ok, err}), '0);
        check(rdata == '0, "R1 idle rdata after reset", rdata[0], '0);
        @(negedge clk);

        // R7: tie right after reset, MEM wins; FETCH stalls through MEM's OK (R5).
        fork
            run_access(0, 1'b1, 0, mk_line(32'h100), 3, "R7 tie reset MEM");
            run_access(1, 1'b1, 4, mk_line(32'h200), 7, "R7 tie reset FETCH R5");
        join
        // R7: FETCH was denied last, so it wins this tie.
        fork
            run_access(0, 1'b0, 5, '0, 7, "R7 tie2 MEM");
            run_access(1, 1'b0, 2, '0, 3, "R7 tie2 FETCH");
        join
        // R7: now MEM was denied last.
        fork
            run_access(0, 1'b1, 12, mk_line(32'h300), 3, "R7 tie3 MEM");
            run_access(1, 1'b1, 16, mk_line(32'h400), 7, "R7 tie3 FETCH");
        join
        // R5: FETCH arrives one cycle into MEM's access.
        fork
            run_access(0, 1'b0, 0, '0, 3, "R5 owner MEM");
            begin
                @(negedge clk);
                run_access(1, 1'b0, 13, '0, 6, "R5 stalled FETCH");
            end
        join
        // R8/R3: MEM abandons a write after two cycles; FETCH takes over.
        fork
            partial_access(0, 1'b1, 8, mk_line(32'h500), 2);
            begin
                @(negedge clk);
                run_access(1, 1'b0, 0, '0, 5, "R8 takeover FETCH");
            end
        join
        run_access(0, 1'b0, 9, '0, D, "R3 abandoned write left line 2");
        // R1: untouched top line reads zero.
        run_access(1, 1'b0, 62, '0, D, "R1 reset contents line 15");
        // R6: one line, four word addresses.
        run_access(0, 1'b1, 5, mk_line(32'h600), D, "R6 write addr 5");
        run_access(1, 1'b0, 4, '0, D, "R6 read addr 4");
        run_access(0, 1'b0, 7, '0, D, "R6 read addr 7");
        run_access(1, 1'b0, 6, '0, D, "R6 read addr 6");
        run_access(0, 1'b0, 8, '0, D, "R6 next line addr 8");
        // R9: out-of-range read and write; aliased line 2 stays untouched.
        run_access(0, 1'b0, 64, '0, D, "R9 read addr 64");
        run_access(1, 1'b1, 202, mk_line(32'h700), D, "R9 write addr 202");
        run_access(0, 1'b0, 10, '0, D, "R9 line 2 unchanged");
        run_access(1, 1'b1, 63, mk_line(32'h800), D, "R9 last word in range");
        run_access(0, 1'b0, 60, '0, D, "R9 R3 read back line 15");

        // R2: DELAY=0 instance completes on first presentation.
        z_req[0] = 1'b1; z_we[0] = 1'b1; z_addr[0] = 8'd9; z_wdata[0] = mk_line(32'h900);
        #1;
        check(z_ok[0] == 1'b1, "R2 zero-delay write ok", LW'(z_ok[0]), 1);
        @(negedge clk);
        z_req[0] = 1'b0; z_we[0] = 1'b0;
        z_req[1] = 1'b1; z_addr[1] = 8'd10;
        #1;
        check(z_ok[1] == 1'b1, "R2 zero-delay read ok", LW'(z_ok[1]), 1);
        check(z_rdata[1] == mk_line(32'h900), "R3 zero-delay read data", z_rdata[1], mk_line(32'h900));
        @(negedge clk);
        // R7 on zero-delay: tie with reset preference, MEM served first.
        z_req[0] = 1'b1; z_addr[0] = 8'd10; z_req[1] = 1'b1;
        #1;
        check(z_ok == 2'b01, "R7 zero-delay tie MEM first", LW'(z_ok), 1);
        @(negedge clk);
        z_req[0] = 1'b0;
        #1;
        check(z_ok == 2'b10, "R7 zero-delay FETCH next", LW'(z_ok), 2);
        @(negedge clk);
        z_req = '0;

        @(negedge clk);
        check(q0.size() == 0 && q1.size() == 0, "R2 all results seen",
              LW'(q0.size() + q1.size()), '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule